// File: doc/BRIEF.md
# Pipelined table-driven CRC-32 engine

This block computes a CRC-32 over a message of arbitrary, unannounced length while taking one 128-bit beat per clock. No shift-register division is used. Every 32-bit word of a beat is turned into its remainder by byte-indexed lookup tables, and each table holds the remainder of one byte value followed by a fixed run of zero bytes. The word that comes last in a beat needs no table, because a 32-bit word is already reduced. The per-word results are registered and then folded by a registered pre-XOR stage. The running remainder goes back into the sum through a table that stands for sixteen zero bytes. The feedback loop therefore holds a single lookup and a two-input XOR, whatever the number of lanes.

The first beat of a message carries one extra word on a separate head input, so it delivers five words. A multiplexer steers the head word into the sixteen-zero-byte path in place of the fed-back remainder. This also throws away whatever the previous message left behind. After the beat flagged last, the accumulated remainder passes once through the four-zero-byte table. The result is then presented with a one-cycle valid pulse.

Top module: `crc32_pipe_engine`

## Requirements
- R1: While reset is high and in the first cycle after it is released, out_valid is 0 and out_crc is 0.
- R2: For a message of a single beat (in_valid, in_first and in_last high together), the message is five 32-bit words in this order: in_head, then in_data[127:96], in_data[95:64], in_data[63:32], in_data[31:0]. out_crc equals M(x)·x^32 mod G(x), where G = 0x104C11DB7 and each word is taken MSB first, the first bit being the highest-order coefficient. There is no preset and no final inversion. An all-zero message gives 0x00000000. A message whose only set bit is bit 0 of its last word gives 0x04C11DB7.
- R3: Every beat after the first adds its four in_data words to the message, in the same order as in R2.
- R4: out_valid is high for exactly one cycle. It rises in the cycle after the third rising edge that follows the edge capturing the last beat, and it is low in the two cycles before that.
- R5: Cycles with in_valid low may fall between the beats of a message. They have no effect on the result, whatever in_data, in_head, in_first and in_last carry in them.
- R6: out_crc keeps its value in every cycle in which out_valid is low.
- R7: A new message may begin in the cycle right after out_valid is high, and its result does not depend on earlier messages.
- R8: in_head is ignored on beats with in_first low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat is present this cycle |
| in_first | input | 1 | The beat opens a message and in_head is valid |
| in_last | input | 1 | The beat closes the message |
| in_head | input | 32 | Leading word of the message, used on the first beat only |
| in_data | input | 128 | Four message words, earliest in bits 127:96 |
| out_valid | output | 1 | One-cycle pulse: out_crc holds a new result |
| out_crc | output | 32 | CRC of the most recent finished message |

## Verification
A beat is captured at edge E0. It reaches the word registers at E0 and the pre-XOR register at E1, updates the accumulator at E2, and drives the result registers at E3. The result therefore appears in the cycle after E3. The bench drives each last beat just after a falling edge. It then checks out_valid low at the falling edges after E1 and E2, checks out_valid high and the CRC value at the falling edge after E3, and checks the pulse low with the CRC unchanged at the falling edge after E4. The next message's first beat is driven at that same falling edge, which puts it in the cycle right after the pulse.

// File: rtl/crc32p_pkg.sv
package crc32p_pkg;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned CRC_BYTES = CRC_W / 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  // remainder of v(x) * x^nbits modulo the generator
  function automatic logic [CRC_W-1:0] zext_rem(input logic [CRC_W-1:0] v,
                                                input int unsigned nbits);
    logic [CRC_W-1:0] r;
    r = v;
    for (int unsigned i = 0; i < nbits; i++)
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/crc32p_zrom.sv
// Word-to-remainder lookup: one 256-entry table per byte position,
// each entry the remainder of that byte followed by ZBYTES zero bytes.
module crc32p_zrom
  import crc32p_pkg::*;
#(
  parameter int unsigned ZBYTES = 4,
  parameter int unsigned NRD    = 1
) (
  input  logic [NRD-1:0][CRC_W-1:0] word_i,
  output logic [NRD-1:0][CRC_W-1:0] rem_o
);
  localparam int unsigned DEPTH = 256;

  logic [CRC_W-1:0] part [CRC_BYTES][NRD];

  for (genvar j = 0; j < CRC_BYTES; j++) begin : g_byte
    logic [CRC_W-1:0] tab [DEPTH];
    initial begin
      for (int e = 0; e < DEPTH; e++)
        tab[e] = zext_rem(CRC_W'(e), 8 * (ZBYTES + j));
    end
    for (genvar p = 0; p < NRD; p++) begin : g_port
      assign part[j][p] = tab[word_i[p][8*j +: 8]];
    end
  end

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rem_o[p] = '0;
      for (int j = 0; j < CRC_BYTES; j++)
        rem_o[p] = rem_o[p] ^ part[j][p];
    end
  end
endmodule

// File: rtl/crc32p_front.sv
// Lane lookups, word register stage and registered pre-XOR stage.
module crc32p_front
  import crc32p_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_first,
  input  logic                     in_last,
  input  logic [CRC_W-1:0]         in_head,
  input  logic [LANES*CRC_W-1:0]   in_data,
  input  logic [CRC_W-1:0]         fin_word_i,
  output logic                     s2_valid_o,
  output logic                     s2_first_o,
  output logic                     s2_last_o,
  output logic [CRC_W-1:0]         s2_head_o,
  output logic [CRC_W-1:0]         s2_pre_o,
  output logic [CRC_W-1:0]         fin_rem_o
);
  localparam int unsigned BEAT_W = LANES * CRC_W;

  logic [CRC_W-1:0] lane_rem [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned ZB = CRC_BYTES * (LANES - 1 - k);
    logic [CRC_W-1:0] lane_word;
    assign lane_word = in_data[BEAT_W-1-k*CRC_W -: CRC_W];
    if (k == LANES - 1) begin : g_plain
      assign lane_rem[k] = lane_word;
    end else if (k == LANES - 2) begin : g_shared
      // the 4-zero-byte table also serves the final step
      logic [1:0][CRC_W-1:0] rd_word, rd_rem;
      assign rd_word = {fin_word_i, lane_word};
      crc32p_zrom #(.ZBYTES(ZB), .NRD(2)) u_rom (.word_i(rd_word), .rem_o(rd_rem));
      assign lane_rem[k] = rd_rem[0];
      assign fin_rem_o   = rd_rem[1];
    end else begin : g_table
      logic [CRC_W-1:0] rd_rem;
      crc32p_zrom #(.ZBYTES(ZB), .NRD(1)) u_rom (.word_i(lane_word), .rem_o(rd_rem));
      assign lane_rem[k] = rd_rem;
    end
  end

  logic             s1_valid, s1_first, s1_last;
  logic [CRC_W-1:0] s1_head;
  logic [CRC_W-1:0] s1_rem [LANES];
  logic [CRC_W-1:0] pre_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s2_valid_o <= 1'b0;
    end else begin
      s1_valid   <= in_valid;
      s2_valid_o <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_first <= in_first;
      s1_last  <= in_last;
      s1_head  <= in_head;
      for (int k = 0; k < LANES; k++) s1_rem[k] <= lane_rem[k];
    end
    if (s1_valid) begin
      s2_first_o <= s1_first;
      s2_last_o  <= s1_last;
      s2_head_o  <= s1_head;
      s2_pre_o   <= pre_c;
    end
  end

  always_comb begin
    pre_c = '0;
    for (int k = 0; k < LANES; k++) pre_c = pre_c ^ s1_rem[k];
  end
endmodule

// File: rtl/crc32p_accum.sv
// Feedback loop (head/feedback select, 16-zero-byte table, two-input XOR)
// and the registered result stage.
module crc32p_accum
  import crc32p_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             s2_first,
  input  logic             s2_last,
  input  logic [CRC_W-1:0] s2_head,
  input  logic [CRC_W-1:0] s2_pre,
  input  logic [CRC_W-1:0] fin_rem_i,
  output logic [CRC_W-1:0] acc_o,
  output logic             out_valid,
  output logic [CRC_W-1:0] out_crc
);
  localparam int unsigned FB_ZBYTES = CRC_BYTES * LANES;

  logic [CRC_W-1:0] acc, fb_sel, fb_rem;
  logic             fin_q;

  assign fb_sel = s2_first ? s2_head : acc;

  crc32p_zrom #(.ZBYTES(FB_ZBYTES), .NRD(1)) u_fb_rom (.word_i(fb_sel), .rem_o(fb_rem));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      fin_q     <= 1'b0;
      out_valid <= 1'b0;
      out_crc   <= '0;
    end else begin
      if (s2_valid) acc <= fb_rem ^ s2_pre;
      fin_q     <= s2_valid & s2_last;
      out_valid <= fin_q;
      if (fin_q) out_crc <= fin_rem_i;
    end
  end

  assign acc_o = acc;
endmodule

// File: rtl/crc32_pipe_engine.sv
module crc32_pipe_engine
  import crc32p_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   in_first,
  input  logic                   in_last,
  input  logic [CRC_W-1:0]       in_head,
  input  logic [LANES*CRC_W-1:0] in_data,
  output logic                   out_valid,
  output logic [CRC_W-1:0]       out_crc
);
  logic             s2_valid, s2_first, s2_last;
  logic [CRC_W-1:0] s2_head, s2_pre, fin_rem, acc;

  crc32p_front #(.LANES(LANES)) u_front (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_last    (in_last),
    .in_head    (in_head),
    .in_data    (in_data),
    .fin_word_i (acc),
    .s2_valid_o (s2_valid),
    .s2_first_o (s2_first),
    .s2_last_o  (s2_last),
    .s2_head_o  (s2_head),
    .s2_pre_o   (s2_pre),
    .fin_rem_o  (fin_rem)
  );

  crc32p_accum #(.LANES(LANES)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .s2_valid  (s2_valid),
    .s2_first  (s2_first),
    .s2_last   (s2_last),
    .s2_head   (s2_head),
    .s2_pre    (s2_pre),
    .fin_rem_i (fin_rem),
    .acc_o     (acc),
    .out_valid (out_valid),
    .out_crc   (out_crc)
  );
endmodule

// File: rtl/crc32p_chk.sv
module crc32p_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_last,
  input logic        out_valid,
  input logic [31:0] out_crc,
  input logic        s2_valid,
  input logic        s2_last
);
  // R4
  result_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last, 4));

  // R4
  result_from_stage_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(s2_valid && s2_last, 2));

  // R5
  stage_valid_chk: assert property (@(posedge clk) disable iff (rst)
    s2_valid |-> $past(in_valid, 2));

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_crc));
endmodule

bind crc32_pipe_engine crc32p_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_crc   (out_crc),
  .s2_valid  (s2_valid),
  .s2_last   (s2_last)
);

// File: tb/crc32_pipe_engine_tb_top.sv
module crc32_pipe_engine_tb_top;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_first, in_last;
  logic [31:0]  in_head;
  logic [127:0] in_data;
  logic         out_valid;
  logic [31:0]  out_crc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit pending = 1'b0;
  logic [31:0] last_crc;
  logic [31:0] msg [64];
  int nwords;

  always #10ns clk = ~clk;

  crc32_pipe_engine dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_head(in_head), .in_data(in_data),
    .out_valid(out_valid), .out_crc(out_crc)
  );

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r;
    logic fb;
    r = '0;
    for (int i = 0; i < n; i++)
      for (int b = 31; b >= 0; b--) begin
        fb = r[31] ^ msg[i][b];
        r  = r << 1;
        if (fb) r = r ^ POLY;
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'($urandom);
    in_last  = 1'($urandom);
    in_head  = $urandom;
    in_data  = {$urandom, $urandom, $urandom, $urandom};
  endtask

  // mode 0: random words, 1: all zero, 2: only bit 0 of last word set
  task automatic run_msg(input int nbeats, input int gapmax, input int mode, input string tag);
    logic [31:0]  w;
    logic [127:0] d;
    logic [31:0]  exp;
    nwords = 0;
    for (int bt = 0; bt < nbeats; bt++) begin
      if (bt > 0) repeat ($urandom_range(gapmax, 0)) idle_cycle();
      @(negedge clk);
      if (pending) begin
        check("R4 pulse end", {31'd0, out_valid}, 32'd0);
        check("R6 hold", out_crc, last_crc);
        pending = 1'b0;
      end
      if (bt == 0) begin
        w = (mode == 0) ? $urandom : 32'd0;
        msg[nwords] = w; nwords++;
        in_head = w;
      end else begin
        in_head = $urandom;  // R8: must be ignored
      end
      for (int k = 0; k < 4; k++) begin
        if (mode == 0) w = $urandom;
        else if (mode == 2 && bt == nbeats - 1 && k == 3) w = 32'd1;
        else w = 32'd0;
        msg[nwords] = w; nwords++;
        d[127-32*k -: 32] = w;
      end
      in_data  = d;
      in_valid = 1'b1;
      in_first = (bt == 0);
      in_last  = (bt == nbeats - 1);
    end
    exp = (mode == 1) ? 32'd0 : (mode == 2) ? 32'h04C11DB7 : ref_crc(nwords);
    idle_cycle();                                   // after capture edge
    idle_cycle();
    check("R4 early", {31'd0, out_valid}, 32'd0);
    idle_cycle();
    check("R4 early", {31'd0, out_valid}, 32'd0);
    idle_cycle();
    check("R4 due", {31'd0, out_valid}, 32'd1);
    check(tag, out_crc, exp);
    last_crc = out_crc;
    pending  = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_head = '0; in_data = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 crc in reset", out_crc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 crc after reset", out_crc, 32'd0);

    run_msg(1, 0, 1, "R2 zero message");
    run_msg(1, 0, 2, "R2 x^32 residue");
    run_msg(3, 0, 2, "R3 x^32 residue multi-beat");
    run_msg(1, 0, 0, "R2/R7 random single beat");
    run_msg(4, 0, 0, "R3/R7/R8 random multi-beat");
    run_msg(5, 4, 0, "R5 bubbles with garbage");
    run_msg(2, 0, 1, "R3/R7 zero after nonzero");
    for (int i = 0; i < 40; i++)
      run_msg($urandom_range(8, 1), $urandom_range(3, 0), 0, "R3/R5/R7/R8 random");
    @(negedge clk);
    if (pending) begin
      check("R4 pulse end", {31'd0, out_valid}, 32'd0);
      check("R6 hold", out_crc, last_crc);
    end
    repeat (3) idle_cycle();
    check("R6 hold idle", out_crc, last_crc);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule